// File: doc/BRIEF.md
# Pulse Tone Channel with Write-Triggered Phase Restart

This block is one square-wave tone channel. Software programs it through a small write port. A control register holds a 2-bit duty selection and a 4-bit volume. The 11-bit period is split across two registers: one holds the low byte and one holds the top three bits. An external tick enable paces a down-counting period divider. Each time the divider reloads, an 8-step duty sequencer moves forward one step. The current step and the duty selection decide whether the channel emits its volume or zero.

The channel copies a well-known quirk of this kind of tone generator. Any write to the top period bits sends the sequencer back to step 0, even when the written value equals the stored one. Over a continuous tone this restart is heard as a click. A write to the low byte changes the pitch and leaves the waveform phase alone. Periods below 8 mute the output.

Top module: `sqch_pulse_chan`

## Requirements
- R1: After reset the duty, volume, period, divider count and sequencer step are all zero, and `sample` is 0.
- R2: A write to address 0 loads the duty from data bits 7:6 and the volume from data bits 3:0. Data bits 5:4 are ignored.
- R3: A write to address 2 loads period bits 7:0 and does not move the sequencer step.
- R4: A write to address 3 loads period bits 10:8 from data bits 2:0 and sets the sequencer to step 0. This happens even when the value is unchanged.
- R5: On a tick with the divider at 0, the divider reloads the period value and the step advances by one, wrapping from 7 to 0. On a tick with a nonzero divider, the divider decrements. One step therefore lasts period+1 ticks.
- R6: The wave is high on these steps: duty 0 on step 1 only; duty 1 on steps 1–2; duty 2 on steps 1–4; duty 3 on every step except 1–2.
- R7: `sample` equals the volume when the wave is high and the period is at least 8. Otherwise `sample` is 0.
- R8: A write to address 1 changes nothing.
- R9: When a write to address 3 falls in the same cycle as a step advance, the step becomes 0.
- R10: In a cycle without a tick, the divider and the step hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Divider clock enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 8 | Write data |
| sample | output | 4 | Amplitude output |

## Verification
All four duty selections are swept over several short periods and volumes for three full sequencer cycles each. This distinguishes pattern errors from divider-length errors. Mid-tone writes to the low byte and to the upper bits are compared to separate a phase-preserving pitch change from a restarting one. Same-value restarts and a restart coinciding with a step advance exercise the priority rule. Periods 7 and 8 probe the mute boundary. Writes to the unused address, writes with unused data bits set, and tick-free cycles show that nothing moves when it should not.

// File: rtl/sqch_pkg.sv
package sqch_pkg;
  localparam int SEQ_STEPS = 8;
  localparam int STEP_W    = $clog2(SEQ_STEPS);

  typedef logic [STEP_W-1:0] step_t;

  typedef enum logic [1:0] {
    ADDR_CTL  = 2'd0,
    ADDR_NONE = 2'd1,
    ADDR_LO   = 2'd2,
    ADDR_HI   = 2'd3
  } reg_addr_e;

  // High-step mask for each duty selection, indexed by step
  function automatic logic [SEQ_STEPS-1:0] duty_mask(input logic [1:0] duty);
    case (duty)
      2'd0:    duty_mask = 8'b0000_0010;
      2'd1:    duty_mask = 8'b0000_0110;
      2'd2:    duty_mask = 8'b0001_1110;
      default: duty_mask = 8'b1111_1001;
    endcase
  endfunction

  function automatic logic wave_bit(input logic [1:0] duty, input step_t step);
    logic [SEQ_STEPS-1:0] m;
    m = duty_mask(duty);
    wave_bit = m[step];
  endfunction

  function automatic step_t next_step(input step_t s);
    next_step = s + step_t'(1);
  endfunction
endpackage

// File: rtl/sqch_regs.sv
module sqch_regs #(
  parameter int PER_W = 11,
  parameter int VOL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [7:0]       wr_data,
  output logic [1:0]       duty,
  output logic [VOL_W-1:0] volume,
  output logic [PER_W-1:0] period,
  output logic             restart_evt
);
  import sqch_pkg::*;
  localparam int HI_W = PER_W - 8;

  logic wr_ctl, wr_lo, wr_hi;
  assign wr_ctl      = wr_en && (wr_addr == ADDR_CTL);
  assign wr_lo       = wr_en && (wr_addr == ADDR_LO);
  assign wr_hi       = wr_en && (wr_addr == ADDR_HI);
  assign restart_evt = wr_hi;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      duty   <= '0;
      volume <= '0;
      period <= '0;
    end else begin
      if (wr_ctl) begin
        duty   <= wr_data[7:6];
        volume <= wr_data[VOL_W-1:0];
      end
      if (wr_lo) period[7:0] <= wr_data;
      if (wr_hi) period[PER_W-1:8] <= wr_data[HI_W-1:0];
    end
  end

  p_low_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> period[7:0] == $past(wr_data));
  p_ctl_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctl |=> (duty == $past(wr_data[7:6])) && (volume == $past(wr_data[VOL_W-1:0])));
  p_unused_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_NONE) |=> $stable(period) && $stable(duty) && $stable(volume));
endmodule

// File: rtl/sqch_timer.sv
module sqch_timer #(
  parameter int PER_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [PER_W-1:0] period,
  output logic             step_adv
);
  logic [PER_W-1:0] cnt;
  logic             at_zero;

  assign at_zero  = (cnt == '0);
  assign step_adv = tick && at_zero;

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= at_zero ? period : cnt - 1'b1;
  end

  p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt == '0) |=> cnt == $past(period));
  p_count_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt != '0) |=> cnt == $past(cnt) - 1'b1);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));
endmodule

// File: rtl/sqch_seq.sv
module sqch_seq (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_adv,
  input  logic             restart,
  output sqch_pkg::step_t  step
);
  import sqch_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n)        step <= '0;
    else if (restart)  step <= '0;
    else if (step_adv) step <= next_step(step);
  end

  p_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> step == '0);
  p_priority_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && step_adv) |=> step == '0);
  p_advance_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_adv && !restart) |=> step == step_t'($past(step) + 3'd1));
  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_adv && !restart) |=> $stable(step));
endmodule

// File: rtl/sqch_pulse_chan.sv
module sqch_pulse_chan #(
  parameter int PER_W    = 11,
  parameter int VOL_W    = 4,
  parameter int MUTE_MIN = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [7:0]       wr_data,
  output logic [VOL_W-1:0] sample
);
  import sqch_pkg::*;

  logic [1:0]       duty;
  logic [VOL_W-1:0] volume;
  logic [PER_W-1:0] period;
  logic             restart_evt;
  logic             step_adv;
  step_t            step;
  logic             wave_hi;
  logic             audible;

  sqch_regs #(.PER_W(PER_W), .VOL_W(VOL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .duty(duty), .volume(volume), .period(period),
    .restart_evt(restart_evt)
  );

  sqch_timer #(.PER_W(PER_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .period(period),
    .step_adv(step_adv)
  );

  sqch_seq u_seq (
    .clk(clk), .rst_n(rst_n), .step_adv(step_adv),
    .restart(restart_evt), .step(step)
  );

  assign wave_hi = wave_bit(duty, step);
  assign audible = (period >= PER_W'(MUTE_MIN));
  assign sample  = (wave_hi && audible) ? volume : '0;

  p_mute_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (period < PER_W'(MUTE_MIN)) |-> sample == '0);
  p_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sample == '0) || (sample == volume));
endmodule

// File: tb/tb_sqch_pulse_chan.sv
module tb_sqch_pulse_chan;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       tick = 0;
  logic       wr_en = 0;
  logic [1:0] wr_addr = 0;
  logic [7:0] wr_data = 0;
  logic [3:0] sample;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  // Bench-side reference state, built from the requirements
  int m_duty = 0, m_vol = 0, m_per = 0, m_cnt = 0, m_step = 0;

  sqch_pulse_chan dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .sample(sample)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic int exp_sample();
    int w;
    bit hi;
    w  = (m_duty == 0) ? 1 : (m_duty == 1) ? 2 : (m_duty == 2) ? 4 : 2;
    hi = (m_step >= 1) && (m_step <= w);
    if (m_duty == 3) hi = !hi;
    return (hi && m_per >= 8) ? m_vol : 0;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input bit t, input bit w, input int a, input int d, input string req);
    bit adv;
    @(negedge clk);
    tick = t; wr_en = w; wr_addr = a[1:0]; wr_data = d[7:0];
    @(posedge clk);
    adv = 0;
    if (t) begin
      if (m_cnt == 0) begin m_cnt = m_per; adv = 1; end
      else m_cnt = m_cnt - 1;
    end
    if (w && a == 3) m_step = 0;
    else if (adv) m_step = (m_step + 1) % 8;
    if (w) begin
      case (a)
        0: begin m_duty = (d >> 6) & 3; m_vol = d & 15; end
        2: m_per = (m_per & 32'h700) | (d & 255);
        3: m_per = (m_per & 255) | ((d & 7) << 8);
        default: ;
      endcase
    end
    #2;
    check(req, sample, exp_sample());
  endtask

  task automatic run(input int n, input string req);
    for (int i = 0; i < n; i++) cyc(1, 0, 0, 0, req);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    check("R1", sample, 0);
    cyc(1, 0, 0, 0, "R1");

    // R6 / R5 / R7: sweep duties, short periods, volumes
    for (int du = 0; du < 4; du++) begin
      for (int pi = 0; pi < 3; pi++) begin
        int per;
        per = (pi == 0) ? 8 : (pi == 1) ? 9 : 13;
        cyc(0, 1, 0, (du << 6) | ((du * 4 + pi + 5) & 15), "R2");
        cyc(0, 1, 2, per, "R3");
        cyc(0, 1, 3, 0, "R4");
        run(3 * 8 * (per + 1), "R6");
      end
    end

    // R2: unused control bits 5:4 set
    cyc(0, 1, 0, 8'b1011_1010, "R2");
    check("R2", m_vol, 10);
    run(40, "R2");

    // R3: low-byte write mid-tone, phase kept
    cyc(0, 1, 2, 11, "R3");
    run(30, "R3");
    cyc(1, 1, 2, 9, "R3");
    run(30, "R3");

    // R4: same-value upper write restarts phase; duty 3 is high at step 0
    cyc(0, 1, 0, 8'hC7, "R4");
    run(25, "R4");
    cyc(0, 1, 3, 0, "R4");
    check("R4", sample, 7);
    run(25, "R4");
    // upper bits nonzero: long period
    cyc(0, 1, 3, 1, "R4");
    run(300, "R4");
    cyc(0, 1, 3, 0, "R4");

    // R9: restart coincident with step advance
    cyc(0, 1, 2, 8, "R9");
    for (int k = 0; k < 3; k++) begin
      while (m_cnt != 0) cyc(1, 0, 0, 0, "R9");
      cyc(1, 1, 3, 0, "R9");
      check("R9", m_step, 0);
      run(5, "R9");
    end

    // R8: write to unused address
    cyc(0, 1, 1, 8'hFF, "R8");
    run(40, "R8");

    // R10: no tick, nothing moves
    for (int k = 0; k < 30; k++) cyc(0, 0, 0, 0, "R10");
    run(20, "R10");

    // R7: mute boundary at 7 vs 8
    cyc(0, 1, 0, 8'hBF, "R7");
    cyc(0, 1, 2, 7, "R7");
    run(64, "R7");
    cyc(0, 1, 2, 8, "R7");
    run(72, "R7");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule